// File: doc/BRIEF.md
# Option Select Setup Controller

This block is the I/O-mapped configuration controller for a board with four expansion connectors and an on-board peripheral group (diskette, serial and parallel interfaces) plus an on-board video function. It decodes byte-wide host I/O cycles on a simple synchronous read/write bus. It holds the board setup register and the adapter setup register. It drives one active-low setup strobe per connector, a channel reset to all connectors, and the setup-select lines for the peripheral group and the video function.

While the peripheral group is in setup, the host can reach two more registers: the on-board option register and the memory enable register. The option register gates the three peripheral enables under a master bit and sets the parallel and serial address assignments. A feedback latch records that a card answered or that an enabled on-board peripheral was accessed, and it clears when it is read.

Software first writes the adapter register to select one connector, then runs byte cycles in the eight-address setup window to reach that adapter's own option registers. Those registers are not part of this block. To configure the on-board group, software clears the group bit in the board register and writes the option register.

Top module: `opt_setup_ctrl`

## Requirements
- R1: After reset, the board register reads 0xFF, the adapter register holds 0 in bits 7, 3 and 2:0, the option register is 0x00, `ram_en_o` is 1 and the feedback bit is 0.
- R2: Address 0x94 is a full read/write byte. `brd_setup_o` is high while bit 7 is 0, and `vid_setup_o` is high while bit 5 is 0.
- R3: At address 0x96, bit 7 drives `chan_reset_o`, bit 3 is the strobe enable and bits 2:0 are the connector code. A read returns bits 6, 5 and 4 as 1, whatever was written to them.
- R4: `card_setup_no[k]` goes low only while the strobe enable is 1, the connector code equals k (codes 0..3 map to connectors 1..4), and a byte read or write is in progress at 0x100..0x107. Codes 4..7 assert no strobe. The strobe follows the current cycle combinationally.
- R5: The option register (0x102) and the memory register (0x103) are written and read back only while board register bit 7 is 0. At other times a write has no effect and a read returns 0xFF.
- R6: Option bit 0 is the master enable. `dsk_en_o`, `ser_en_o` and `par_en_o` equal the master bit ANDed with option bit 1, bit 2 and bit 4 respectively.
- R7: Option bits 6:5 set `par_base_o`: 00 gives 0x3BC, 01 gives 0x378, 10 gives 0x278. Code 11 is reserved, forces `par_en_o` to 0 and gives base 0. `par_bidir_o` is the inverse of option bit 7.
- R8: When option bit 3 is 1, `ser_base_o` is 0x3F8 and `ser_irq_o` is 4. When bit 3 is 0, they are 0x2F8 and 3.
- R9: Address 0x91 reads {7'b0, fb}. At a clock edge, fb becomes 1 if an event occurs in that cycle. Otherwise fb becomes 0 if the cycle is a byte read of 0x91, and otherwise it holds. An event is `card_fb_ni` low or an on-board hit. When an event and a clearing read fall in the same cycle, fb stays 1.
- R10: An on-board hit is a read or write of any width that falls in an enabled peripheral range: 0x3F0..0x3F7 for the diskette, serial base..base+7, or parallel base..base+3.
- R11: Bit 0 written to 0x103 during setup drives `ram_en_o`. A read of 0x103 returns {7'b0, ram_en}.
- R12: A 16-bit access (`io_wide_i` high) writes no register, asserts no strobe, does not clear fb, and reads 0xFF. A byte read of any address this block does not own also returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | Write data |
| io_wr_i | input | 1 | Write cycle |
| io_rd_i | input | 1 | Read cycle |
| io_wide_i | input | 1 | Access is 16 bits wide |
| card_fb_ni | input | 1 | Card-selected feedback, active low |
| io_rdata_o | output | 8 | Read data |
| card_setup_no | output | 4 | Per-connector setup strobes, active low |
| chan_reset_o | output | 1 | Channel reset to all connectors |
| brd_setup_o | output | 1 | On-board peripheral group in setup |
| vid_setup_o | output | 1 | Video function in setup |
| dsk_en_o | output | 1 | Diskette interface enable |
| ser_en_o | output | 1 | Serial port enable |
| par_en_o | output | 1 | Parallel port enable |
| par_bidir_o | output | 1 | Parallel bidirectional mode |
| par_base_o | output | 16 | Parallel port base address |
| ser_base_o | output | 16 | Serial port base address |
| ser_irq_o | output | 4 | Serial interrupt level |
| ram_en_o | output | 1 | On-board memory enable |

## Verification
Read data and the connector strobes are combinational from the current cycle and the register state. The bench drives each cycle at the falling edge and samples them 2 ns later, before the rising edge. Register writes, the outputs derived from them, and feedback set and clear all take effect at the next rising edge. The bench updates its model there, and the next cycle's falling-edge sample checks the new values. Random cycles also drive `card_fb_ni` and hit peripheral ranges, so a feedback event can land in the same cycle as a clearing read of 0x91.

// File: rtl/opt_setup_pkg.sv
package opt_setup_pkg;
  localparam logic [15:0] A_FB     = 16'h0091;
  localparam logic [15:0] A_BRD    = 16'h0094;
  localparam logic [15:0] A_ADP    = 16'h0096;
  localparam logic [15:0] A_OPT    = 16'h0102;
  localparam logic [15:0] A_RAM    = 16'h0103;
  localparam logic [15:0] WIN_BASE = 16'h0100;
  localparam logic [15:0] DSK_BASE = 16'h03F0;
  localparam logic [15:0] SER_PRI  = 16'h03F8;
  localparam logic [15:0] SER_SEC  = 16'h02F8;
  localparam logic [15:0] PAR_A    = 16'h03BC;
  localparam logic [15:0] PAR_B    = 16'h0378;
  localparam logic [15:0] PAR_C    = 16'h0278;

  typedef struct packed {
    logic       bidir_off;
    logic [1:0] par_sel;
    logic       par_on;
    logic       ser_pri;
    logic       ser_on;
    logic       dsk_on;
    logic       master;
  } opt_t;
endpackage

// File: rtl/opt_setup_regs.sv
module opt_setup_regs
  import opt_setup_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              wide_i,
  input  logic              fb_evt_i,
  output logic [7:0]        brd_o,
  output logic              ch_rst_o,
  output logic              setup_en_o,
  output logic [SEL_W-1:0]  sel_o,
  output opt_t              opt_o,
  output logic              ram_o,
  output logic [7:0]        rdata_o
);
  logic byte_acc, in_setup;
  logic is_fb, is_brd, is_adp, is_opt, is_ram;
  logic fb_q;

  assign byte_acc = !wide_i;
  assign in_setup = !brd_o[7];
  assign is_fb  = byte_acc && (addr_i == ADDR_W'(A_FB));
  assign is_brd = byte_acc && (addr_i == ADDR_W'(A_BRD));
  assign is_adp = byte_acc && (addr_i == ADDR_W'(A_ADP));
  assign is_opt = byte_acc && in_setup && (addr_i == ADDR_W'(A_OPT));
  assign is_ram = byte_acc && in_setup && (addr_i == ADDR_W'(A_RAM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brd_o      <= 8'hFF;
      ch_rst_o   <= 1'b0;
      setup_en_o <= 1'b0;
      sel_o      <= '0;
      opt_o      <= '0;
      ram_o      <= 1'b1;
      fb_q       <= 1'b0;
    end else begin
      if (wr_i && is_brd) brd_o <= wdata_i;
      if (wr_i && is_adp) begin
        ch_rst_o   <= wdata_i[7];
        setup_en_o <= wdata_i[3];
        sel_o      <= wdata_i[SEL_W-1:0];
      end
      if (wr_i && is_opt) opt_o <= opt_t'(wdata_i);
      if (wr_i && is_ram) ram_o <= wdata_i[0];
      if (fb_evt_i)              fb_q <= 1'b1;
      else if (rd_i && is_fb)    fb_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = 8'hFF;
    if (is_fb)       rdata_o = {7'b0, fb_q};
    else if (is_brd) rdata_o = brd_o;
    else if (is_adp) begin
      rdata_o = {ch_rst_o, 3'b111, setup_en_o, 3'b000};
      rdata_o[SEL_W-1:0] = sel_o;
    end
    else if (is_opt) rdata_o = opt_o;
    else if (is_ram) rdata_o = {7'b0, ram_o};
  end
endmodule

// File: rtl/opt_setup_periph.sv
module opt_setup_periph
  import opt_setup_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  opt_t              opt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              acc_i,
  output logic              dsk_en_o,
  output logic              ser_en_o,
  output logic              par_en_o,
  output logic              par_bidir_o,
  output logic [ADDR_W-1:0] par_base_o,
  output logic [ADDR_W-1:0] ser_base_o,
  output logic [3:0]        ser_irq_o,
  output logic              hit_o
);
  localparam int DSK_SPAN = 8;
  localparam int SER_SPAN = 8;
  localparam int PAR_SPAN = 4;

  function automatic logic in_rng(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] b,
                                  input int unsigned span);
    return (a >= b) && (a < b + ADDR_W'(span));
  endfunction

  logic par_ok;

  always_comb begin
    par_ok = 1'b1;
    unique case (opt_i.par_sel)
      2'b00:   par_base_o = ADDR_W'(PAR_A);
      2'b01:   par_base_o = ADDR_W'(PAR_B);
      2'b10:   par_base_o = ADDR_W'(PAR_C);
      default: begin par_base_o = '0; par_ok = 1'b0; end
    endcase
  end

  assign ser_base_o  = opt_i.ser_pri ? ADDR_W'(SER_PRI) : ADDR_W'(SER_SEC);
  assign ser_irq_o   = opt_i.ser_pri ? 4'd4 : 4'd3;
  assign dsk_en_o    = opt_i.master && opt_i.dsk_on;
  assign ser_en_o    = opt_i.master && opt_i.ser_on;
  assign par_en_o    = opt_i.master && opt_i.par_on && par_ok;
  assign par_bidir_o = !opt_i.bidir_off;

  assign hit_o = acc_i && (
      (dsk_en_o && in_rng(addr_i, ADDR_W'(DSK_BASE), DSK_SPAN)) ||
      (ser_en_o && in_rng(addr_i, ser_base_o, SER_SPAN)) ||
      (par_en_o && in_rng(addr_i, par_base_o, PAR_SPAN)));
endmodule

// File: rtl/opt_setup_strobe.sv
module opt_setup_strobe
  import opt_setup_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_SLOT = 4,
  parameter int SEL_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              acc_i,
  input  logic              wide_i,
  input  logic              setup_en_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [N_SLOT-1:0] card_setup_no
);
  localparam int WIN_LSB = 3;
  logic fire;

  assign fire = setup_en_i && acc_i && !wide_i &&
                (addr_i[ADDR_W-1:WIN_LSB] == (ADDR_W-WIN_LSB)'(WIN_BASE >> WIN_LSB));

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    assign card_setup_no[i] = !(fire && (sel_i == SEL_W'(i)));
  end
endmodule

// File: rtl/opt_setup_ctrl.sv
module opt_setup_ctrl
  import opt_setup_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_SLOT = 4,
  parameter int SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [7:0]        io_wdata_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic              io_wide_i,
  input  logic              card_fb_ni,
  output logic [7:0]        io_rdata_o,
  output logic [N_SLOT-1:0] card_setup_no,
  output logic              chan_reset_o,
  output logic              brd_setup_o,
  output logic              vid_setup_o,
  output logic              dsk_en_o,
  output logic              ser_en_o,
  output logic              par_en_o,
  output logic              par_bidir_o,
  output logic [ADDR_W-1:0] par_base_o,
  output logic [ADDR_W-1:0] ser_base_o,
  output logic [3:0]        ser_irq_o,
  output logic              ram_en_o
);
  logic [7:0]       brd_q;
  logic             setup_en;
  logic [SEL_W-1:0] sel;
  opt_t             opt_q;
  logic             hit, acc;

  assign acc = io_rd_i || io_wr_i;

  opt_setup_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i    (io_addr_i),
    .wdata_i   (io_wdata_i),
    .wr_i      (io_wr_i),
    .rd_i      (io_rd_i),
    .wide_i    (io_wide_i),
    .fb_evt_i  (!card_fb_ni || hit),
    .brd_o     (brd_q),
    .ch_rst_o  (chan_reset_o),
    .setup_en_o(setup_en),
    .sel_o     (sel),
    .opt_o     (opt_q),
    .ram_o     (ram_en_o),
    .rdata_o   (io_rdata_o)
  );

  opt_setup_periph #(.ADDR_W(ADDR_W)) u_periph (
    .opt_i      (opt_q),
    .addr_i     (io_addr_i),
    .acc_i      (acc),
    .dsk_en_o,
    .ser_en_o,
    .par_en_o,
    .par_bidir_o,
    .par_base_o,
    .ser_base_o,
    .ser_irq_o,
    .hit_o      (hit)
  );

  opt_setup_strobe #(.ADDR_W(ADDR_W), .N_SLOT(N_SLOT), .SEL_W(SEL_W)) u_strobe (
    .addr_i       (io_addr_i),
    .acc_i        (acc),
    .wide_i       (io_wide_i),
    .setup_en_i   (setup_en),
    .sel_i        (sel),
    .card_setup_no
  );

  assign brd_setup_o = !brd_q[7];
  assign vid_setup_o = !brd_q[5];
endmodule

// File: rtl/opt_setup_chk.sv
module opt_setup_chk #(
  parameter int ADDR_W = 16,
  parameter int N_SLOT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic              io_wide_i,
  input logic [N_SLOT-1:0] card_setup_no,
  input logic              chan_reset_o,
  input logic              brd_setup_o,
  input logic              dsk_en_o,
  input logic              ser_en_o,
  input logic              par_en_o,
  input logic [ADDR_W-1:0] ser_base_o,
  input logic [3:0]        ser_irq_o,
  input logic              ram_en_o
);
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~card_setup_no)); // R4
  AST_STROBE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_setup_no != '1) |-> ((io_rd_i || io_wr_i) && !io_wide_i &&
      (io_addr_i >= ADDR_W'(16'h0100)) && (io_addr_i <= ADDR_W'(16'h0107)))); // R4
  AST_CHRST_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> $stable(chan_reset_o)); // R3
  AST_OPT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brd_setup_o |=> $stable({dsk_en_o, ser_en_o, par_en_o})); // R5
  AST_RAM_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brd_setup_o |=> $stable(ram_en_o)); // R11
  AST_SER_IRQ_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_base_o == ADDR_W'(16'h03F8)) ? (ser_irq_o == 4'd4) : (ser_irq_o == 4'd3)); // R8
endmodule

bind opt_setup_ctrl opt_setup_chk #(.ADDR_W(ADDR_W), .N_SLOT(N_SLOT)) u_chk (
  .clk_i, .rst_ni, .io_addr_i, .io_wr_i, .io_rd_i, .io_wide_i,
  .card_setup_no, .chan_reset_o, .brd_setup_o, .dsk_en_o, .ser_en_o,
  .par_en_o, .ser_base_o, .ser_irq_o, .ram_en_o
);

// File: tb/opt_setup_ctrl_bench.sv
`timescale 1ns/1ps
module opt_setup_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0, wide = 1'b0, fbn = 1'b1;
  logic [7:0]  rdata;
  logic [3:0]  cs_n;
  logic        ch_rst, brd_su, vid_su, dsk_en, ser_en, par_en, par_bidir, ram_en;
  logic [15:0] par_base, ser_base;
  logic [3:0]  ser_irq;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [7:0] m_brd = 8'hFF;
  logic       m_ch = 0, m_se = 0, m_ram = 1, m_fb = 0;
  logic [2:0] m_sel = 0;
  logic [7:0] m_opt = 8'h00;

  always #10 clk = ~clk;

  opt_setup_ctrl u_opt_setup_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wdata_i(wdata),
    .io_wr_i(wr), .io_rd_i(rd), .io_wide_i(wide), .card_fb_ni(fbn),
    .io_rdata_o(rdata), .card_setup_no(cs_n), .chan_reset_o(ch_rst),
    .brd_setup_o(brd_su), .vid_setup_o(vid_su), .dsk_en_o(dsk_en),
    .ser_en_o(ser_en), .par_en_o(par_en), .par_bidir_o(par_bidir),
    .par_base_o(par_base), .ser_base_o(ser_base), .ser_irq_o(ser_irq),
    .ram_en_o(ram_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] e_par_base();
    case (m_opt[6:5])
      2'b00: return 16'h03BC;
      2'b01: return 16'h0378;
      2'b10: return 16'h0278;
      default: return 16'h0000;
    endcase
  endfunction
  function automatic logic e_par_en();
    return m_opt[0] && m_opt[4] && (m_opt[6:5] != 2'b11);
  endfunction
  function automatic logic [15:0] e_ser_base();
    return m_opt[3] ? 16'h03F8 : 16'h02F8;
  endfunction

  function automatic logic e_hit(input logic [15:0] a, input logic acc);
    logic h;
    h = (m_opt[0] && m_opt[1] && a >= 16'h03F0 && a <= 16'h03F7) ||
        (m_opt[0] && m_opt[2] && a >= e_ser_base() && a <= e_ser_base() + 16'd7) ||
        (e_par_en() && a >= e_par_base() && a <= e_par_base() + 16'd3);
    return acc && h;
  endfunction

  function automatic logic [7:0] e_rdata(input logic [15:0] a, input logic w);
    if (w) return 8'hFF;
    case (a)
      16'h0091: return {7'b0, m_fb};
      16'h0094: return m_brd;
      16'h0096: return {m_ch, 3'b111, m_se, m_sel};
      16'h0102: return m_brd[7] ? 8'hFF : m_opt;
      16'h0103: return m_brd[7] ? 8'hFF : {7'b0, m_ram};
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic [3:0] e_strobe(input logic [15:0] a, input logic acc, input logic w);
    logic [3:0] s;
    s = 4'hF;
    if (m_se && acc && !w && a[15:3] == 13'h0020 && m_sel < 3'd4) s[m_sel[1:0]] = 1'b0;
    return s;
  endfunction

  task automatic check_outs();
    check("R2 brd_setup", brd_su, !m_brd[7]);
    check("R2 vid_setup", vid_su, !m_brd[5]);
    check("R3 chan_reset", ch_rst, m_ch);
    check("R6 dsk_en", dsk_en, m_opt[0] && m_opt[1]);
    check("R6 ser_en", ser_en, m_opt[0] && m_opt[2]);
    check("R7 par_en", par_en, e_par_en());
    check("R7 par_base", par_base, e_par_base());
    check("R7 par_bidir", par_bidir, !m_opt[7]);
    check("R8 ser_base", ser_base, e_ser_base());
    check("R8 ser_irq", ser_irq, m_opt[3] ? 4'd4 : 4'd3);
    check("R11 ram_en", ram_en, m_ram);
  endtask

  // one bus cycle: drive at falling edge, sample combinational results, update model at rising edge
  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic w_en,
                     input logic r_en, input logic w16, input logic fb_n);
    logic ev;
    @(negedge clk);
    addr = a; wdata = d; wr = w_en; rd = r_en; wide = w16; fbn = fb_n;
    #2;
    check_outs();
    check(w16 ? "R4/R12 strobe" : "R4 strobe", cs_n, e_strobe(a, w_en || r_en, w16));
    if (r_en) check(w16 ? "R12 rdata" : (a == 16'h0091 ? "R9 rdata" : "R5 rdata"),
                    rdata, e_rdata(a, w16));
    @(posedge clk);
    ev = !fb_n || e_hit(a, w_en || r_en);
    if (w_en && !w16) begin
      case (a)
        16'h0094: m_brd = d;
        16'h0096: begin m_ch = d[7]; m_se = d[3]; m_sel = d[2:0]; end
        16'h0102: if (!m_brd[7]) m_opt = d;
        16'h0103: if (!m_brd[7]) m_ram = d[0];
        default: ;
      endcase
    end
    if (ev) m_fb = 1'b1;
    else if (r_en && !w16 && a == 16'h0091) m_fb = 1'b0;
  endtask

  task automatic wr8(input logic [15:0] a, input logic [7:0] d); cyc(a, d, 1, 0, 0, 1); endtask
  task automatic rd8(input logic [15:0] a);                   cyc(a, 0, 0, 1, 0, 1); endtask
  task automatic idle();                                      cyc(16'h0000, 0, 0, 0, 0, 1); endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20250611);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #2;
    check("R1 brd_setup", brd_su, 1'b0);
    check("R1 ram_en", ram_en, 1'b1);
    check("R1 strobes", cs_n, 4'hF);
    check("R1 par_bidir", par_bidir, 1'b1);
    rd8(16'h0094); rd8(16'h0096); rd8(16'h0091); rd8(16'h0102);
    // R3 reserved read-as-one
    wr8(16'h0096, 8'h00); rd8(16'h0096);
    wr8(16'h0096, 8'h70); rd8(16'h0096);
    // R4 each connector, and codes 4..7 give none
    for (int c = 0; c < 8; c++) begin
      wr8(16'h0096, 8'h08 | 8'(c));
      rd8(16'h0100 + 16'(c));
      wr8(16'h0107, 8'h55);
      rd8(16'h0108);
      cyc(16'h0104, 0, 0, 1, 1, 1); // R12 wide in window
    end
    wr8(16'h0096, 8'h80); idle(); wr8(16'h0096, 8'h00);
    // R5 locked outside setup
    wr8(16'h0102, 8'h17); rd8(16'h0102); wr8(16'h0103, 8'h00); rd8(16'h0103);
    // enter setup, program options
    wr8(16'h0094, 8'h7F);
    wr8(16'h0102, 8'h1E); rd8(16'h0102);                   // R6 master off
    wr8(16'h0102, 8'h1F); rd8(16'h0102);                   // R6 all on
    wr8(16'h0102, 8'h7F); idle();                          // R7 reserved code
    wr8(16'h0102, 8'hB7); idle();                          // R7/R8 bit3=0
    wr8(16'h0103, 8'hFE); rd8(16'h0103); wr8(16'h0103, 8'h01); // R11
    cyc(16'h0103, 8'h00, 1, 0, 1, 1); rd8(16'h0103);        // R12 wide write ignored
    // R9/R10 feedback
    rd8(16'h0091); rd8(16'h0091);
    cyc(16'h0000, 0, 0, 0, 0, 0); rd8(16'h0091); rd8(16'h0091);
    cyc(16'h0091, 0, 0, 1, 0, 0); rd8(16'h0091);            // R9 set wins over clear
    rd8(16'h0378); rd8(16'h0091);                           // R10 parallel hit
    rd8(16'h02F8); rd8(16'h0091);                           // R10 serial hit
    cyc(16'h0091, 0, 0, 1, 1, 1); rd8(16'h0091);            // R12 wide read does not clear
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [1:0]  op;
      case ($urandom % 11)
        0: a = 16'h0091;  1: a = 16'h0094;  2: a = 16'h0096;
        3: a = 16'h0102;  4: a = 16'h0103;
        5: a = 16'h0100 + 16'($urandom % 8);
        6: a = 16'h03F0 + 16'($urandom % 16);
        7: a = 16'h03BC + 16'($urandom % 4);
        8: a = 16'h0278 + 16'($urandom % 8);
        9: a = 16'h02F8 + 16'($urandom % 8);
        default: a = 16'($urandom);
      endcase
      op = 2'($urandom % 3);
      cyc(a, 8'($urandom), op == 2'd1, op == 2'd2, ($urandom % 8) == 0, ($urandom % 6) != 0);
    end
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule